// File: doc/BRIEF.md
# Calibration Busy Gating Registers

This block is a small soft register slice on a memory-mapped configuration port. The physical layer gives one raw calibration-busy signal, and that signal rises for a transmit calibration and for a receive calibration alike. The block splits it into a transmit busy output and a receive busy output, and each output has its own enable bit. Logic that resets a transmitter or receiver on busy can then be shielded from the other direction's calibration. Before handing the configuration bus back to the calibration engine, software clears the transmit enable when a receive calibration is coming, or clears the receive enable when a transmit calibration is coming.

One control/status word at a fixed word address holds both enables and reports the gated busy state. It also reports whether the calibration engine or the user currently owns the configuration bus. Reads are served directly from soft logic with a fixed one-cycle latency. They never wait for arbitration, so software can poll the word while calibration runs.

Top module: `calbusy_gate_regs`

## Requirements
- R1: After reset both enables are 1, so a read of the control word at 0x281 with busy and owner low returns 0x30.
- R2: A write to address 0x281 loads bit 5 into the receive enable and bit 4 into the transmit enable at the clock edge of the write strobe.
- R3: `rx_cal_busy` equals the raw busy input ANDed with the receive enable, in the same cycle and with no register delay.
- R4: `tx_cal_busy` equals the raw busy input ANDed with the transmit enable, in the same cycle and with no register delay.
- R5: In the read word, bit 1 is raw busy ANDed with the receive enable and bit 0 is raw busy ANDed with the transmit enable, both sampled at the read strobe edge. Bits 5 and 4 show the receive and transmit enables.
- R6: Read word bit 2 is 1 when the calibration engine owns the bus and 0 when the user owns it, sampled at the read strobe edge.
- R7: Write data bits 2:0 and all bits other than 5 and 4 have no effect. Read word bits 3 and 6 and above are always 0.
- R8: Read data appears in the cycle after the read strobe, whatever the busy and owner inputs are. A read and a write in the same cycle return the enables from before the write. `cfg_rdata` is zero in every cycle that does not follow a read strobe.
- R9: An access to any address other than 0x281 reads as zero and changes no enable. The full address is decoded.
- R10: When both enables are 0, neither busy output nor status bits 1:0 ever go high, whatever the raw busy input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | ADDR_W (10) | Word address of the access |
| cfg_write | input | 1 | Write strobe, one cycle per write |
| cfg_wdata | input | DATA_W (32) | Write data |
| cfg_read | input | 1 | Read strobe, one cycle per read |
| cfg_rdata | output | DATA_W (32) | Read data, valid the cycle after the read strobe |
| phy_cal_busy | input | 1 | Raw shared calibration busy from the physical layer |
| engine_owns_bus | input | 1 | 1 while the calibration engine holds the configuration bus |
| tx_cal_busy | output | 1 | Gated transmit calibration busy |
| rx_cal_busy | output | 1 | Gated receive calibration busy |

## Verification
The hardest case to reach is a control word read in the same cycle as a write to it while the raw busy input toggles. The returned status must carry the old enables, and the outputs must switch to the new ones one edge later. The bench reaches this case with a directed read-plus-write cycle and then with a long run of random strobes, data, busy and owner values. A reference model checks every cycle. Directed sequences also clear both enables and toggle busy repeatedly to show that the outputs and status stay silent. Writes with bits 2:0 set, and accesses to near-miss addresses (0x280, 0x282, 0x081), show that nothing leaks into the enables.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
   localparam int unsigned CBG_NUM_DIR = 2;
   localparam int unsigned CBG_DIR_TX  = 0;
   localparam int unsigned CBG_DIR_RX  = 1;
   typedef logic [CBG_NUM_DIR-1:0] cbg_dir_vec_t;
endpackage

// File: rtl/cbg_enable_reg.sv
module cbg_enable_reg #(
   parameter int unsigned         NUM_DIR   = 2,
   parameter logic [NUM_DIR-1:0]  RESET_VAL = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_hit,
   input  logic [NUM_DIR-1:0] wr_bits,
   output logic [NUM_DIR-1:0] en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en <= RESET_VAL;
      else if (wr_hit) en <= wr_bits;
   end

   // R2
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> en == $past(wr_bits));
   // R9
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(en));
endmodule

// File: rtl/cbg_busy_gate.sv
module cbg_busy_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_busy,
   input  logic enable,
   output logic gated
);
   assign gated = raw_busy & enable;

   // R10
   gate_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !gated);
   // R3
   gate_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gated |-> raw_busy);
endmodule

// File: rtl/cbg_read_port.sv
module cbg_read_port #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_DIR   = 2,
   parameter int unsigned EN_LSB    = 4,
   parameter int unsigned STAT_LSB  = 0,
   parameter int unsigned OWNER_BIT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_hit,
   input  logic               rd_any,
   input  logic [NUM_DIR-1:0] en,
   input  logic [NUM_DIR-1:0] status,
   input  logic               owner,
   output logic [DATA_W-1:0]  rdata
);
   localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] DIR_ONES  = (ONE << NUM_DIR) - ONE;
   localparam logic [DATA_W-1:0] LIVE_MASK =
      (DIR_ONES << EN_LSB) | (DIR_ONES << STAT_LSB) | (ONE << OWNER_BIT);

   logic [DATA_W-1:0] word;

   always_comb begin
      word = '0;
      for (int i = 0; i < int'(NUM_DIR); i++) begin
         word[EN_LSB + i]   = en[i];
         word[STAT_LSB + i] = status[i];
      end
      word[OWNER_BIT] = owner;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (rd_hit) rdata <= word;
      else             rdata <= '0;
   end

   // R7
   rd_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rdata & ~LIVE_MASK) == '0);
   // R6
   rd_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> rdata[OWNER_BIT] == $past(owner));
   // R8
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_any |=> rdata == '0);
endmodule

// File: rtl/calbusy_gate_regs.sv
module calbusy_gate_regs
   import cbg_pkg::*;
#(
   parameter int unsigned         ADDR_W    = 10,
   parameter int unsigned         DATA_W    = 32,
   parameter logic [ADDR_W-1:0]   CTRL_ADDR = 10'h281,
   parameter int unsigned         EN_LSB    = 4,
   parameter int unsigned         STAT_LSB  = 0,
   parameter int unsigned         OWNER_BIT = 2,
   parameter logic [CBG_NUM_DIR-1:0] EN_RESET = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_write,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              cfg_read,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              phy_cal_busy,
   input  logic              engine_owns_bus,
   output logic              tx_cal_busy,
   output logic              rx_cal_busy
);
   localparam int unsigned NUM_DIR = CBG_NUM_DIR;

   if (EN_LSB + NUM_DIR > DATA_W || STAT_LSB + NUM_DIR > DATA_W ||
       OWNER_BIT >= DATA_W) begin : g_bad_width
      $error("calbusy_gate_regs: field does not fit in DATA_W");
   end
   if ((OWNER_BIT >= EN_LSB && OWNER_BIT < EN_LSB + NUM_DIR) ||
       (OWNER_BIT >= STAT_LSB && OWNER_BIT < STAT_LSB + NUM_DIR) ||
       (EN_LSB < STAT_LSB + NUM_DIR && STAT_LSB < EN_LSB + NUM_DIR)) begin : g_bad_layout
      $error("calbusy_gate_regs: register fields overlap");
   end

   logic         wr_hit, rd_hit;
   cbg_dir_vec_t en, gated, wr_bits;
   logic         unused_wdata;

   assign wr_hit       = cfg_write && (cfg_addr == CTRL_ADDR);
   assign rd_hit       = cfg_read  && (cfg_addr == CTRL_ADDR);
   assign wr_bits      = cfg_wdata[EN_LSB +: NUM_DIR];
   assign unused_wdata = ^cfg_wdata;

   cbg_enable_reg #(
      .NUM_DIR   (NUM_DIR),
      .RESET_VAL (EN_RESET)
   ) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit),
      .wr_bits (wr_bits),
      .en      (en)
   );

   for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      cbg_busy_gate u_gate (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw_busy (phy_cal_busy),
         .enable   (en[d]),
         .gated    (gated[d])
      );
   end

   assign tx_cal_busy = gated[CBG_DIR_TX];
   assign rx_cal_busy = gated[CBG_DIR_RX];

   cbg_read_port #(
      .DATA_W    (DATA_W),
      .NUM_DIR   (NUM_DIR),
      .EN_LSB    (EN_LSB),
      .STAT_LSB  (STAT_LSB),
      .OWNER_BIT (OWNER_BIT)
   ) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_hit (rd_hit),
      .rd_any (cfg_read),
      .en     (en),
      .status (gated),
      .owner  (engine_owns_bus),
      .rdata  (cfg_rdata)
   );

   // R4
   tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_cal_busy && en[CBG_DIR_TX]) |-> tx_cal_busy);
   // R3
   rx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_cal_busy && en[CBG_DIR_RX]) |-> rx_cal_busy);
   // R9
   miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_read && cfg_addr != CTRL_ADDR) |=> cfg_rdata == '0);
   // R5
   stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> cfg_rdata[STAT_LSB +: NUM_DIR] == $past(gated));
endmodule

// File: tb/calbusy_gate_regs_bench.sv
module calbusy_gate_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  cfg_addr = '0;
   logic        cfg_write = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        cfg_read = 1'b0;
   logic [31:0] cfg_rdata;
   logic        phy_cal_busy = 1'b0;
   logic        engine_owns_bus = 1'b0;
   logic        tx_cal_busy, rx_cal_busy;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   bit m_rx_en = 1'b1;
   bit m_tx_en = 1'b1;

   always #5 clk = ~clk;

   calbusy_gate_regs u_calbusy_gate_regs (
      .clk (clk), .rst_n (rst_n), .cfg_addr (cfg_addr), .cfg_write (cfg_write),
      .cfg_wdata (cfg_wdata), .cfg_read (cfg_read), .cfg_rdata (cfg_rdata),
      .phy_cal_busy (phy_cal_busy), .engine_owns_bus (engine_owns_bus),
      .tx_cal_busy (tx_cal_busy), .rx_cal_busy (rx_cal_busy)
   );

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // One cycle: drive, check combinational outputs, step the model, check read data.
   task automatic step(string tag, logic [9:0] a, bit rd, bit wr, logic [31:0] wd,
                       bit busy, bit own);
      logic [31:0] exp_rd;
      bit          nrx, ntx;
      cfg_addr = a; cfg_read = rd; cfg_write = wr; cfg_wdata = wd;
      phy_cal_busy = busy; engine_owns_bus = own;
      #1;
      check((!m_rx_en && !m_tx_en) ? "R10" : "R3", "rx_cal_busy", 32'(rx_cal_busy), 32'(busy && m_rx_en));
      check((!m_rx_en && !m_tx_en) ? "R10" : "R4", "tx_cal_busy", 32'(tx_cal_busy), 32'(busy && m_tx_en));
      exp_rd = 32'h0;
      if (rd && a == 10'h281) begin
         exp_rd[5] = m_rx_en;
         exp_rd[4] = m_tx_en;
         exp_rd[2] = own;
         exp_rd[1] = busy && m_rx_en;
         exp_rd[0] = busy && m_tx_en;
      end
      nrx = m_rx_en; ntx = m_tx_en;
      if (wr && a == 10'h281) begin
         nrx = wd[5];
         ntx = wd[4];
      end
      @(posedge clk);
      #1;
      m_rx_en = nrx; m_tx_en = ntx;
      check(tag, "cfg_rdata", cfg_rdata, exp_rd);
   endtask

   initial begin : watchdog
      while (cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<5000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      #1;
      repeat (3) @(posedge clk);
      #1;
      check("R1", "rdata in reset", cfg_rdata, 32'h0);
      rst_n = 1'b1;
      // R1: defaults after reset
      step("R1", 10'h281, 1, 0, 0, 0, 0);
      // R5: shared busy drives both status bits
      step("R5", 10'h281, 1, 0, 0, 1, 0);
      // R6: ownership flag
      step("R6", 10'h281, 1, 0, 0, 0, 1);
      // R8: reads served during busy with engine owning; idle cycle reads zero
      step("R8", 10'h281, 1, 0, 0, 1, 1);
      step("R8", 10'h281, 0, 0, 0, 1, 1);
      // R2: receive calibration coming, clear transmit enable
      step("R2", 10'h281, 0, 1, 32'h20, 0, 0);
      step("R5", 10'h281, 1, 0, 0, 1, 1);
      // R2: transmit calibration coming, clear receive enable; same-cycle read sees old
      step("R8", 10'h281, 1, 1, 32'h10, 1, 0);
      step("R5", 10'h281, 1, 0, 0, 1, 0);
      // R7: bits other than 5:4 ignored; all ones restores both enables
      step("R7", 10'h281, 0, 1, 32'hFFFF_FFCF, 0, 0);
      step("R7", 10'h281, 1, 0, 0, 1, 1);
      step("R7", 10'h281, 0, 1, 32'hFFFF_FFFF, 0, 0);
      step("R7", 10'h281, 1, 0, 0, 1, 1);
      // R10: both enables cleared, busy toggling stays silent
      step("R10", 10'h281, 0, 1, 32'h0000_0007, 1, 0);
      for (int i = 0; i < 6; i++) step("R10", 10'h281, 1, 0, 0, i[0], 1);
      // R9: other addresses
      step("R9", 10'h280, 0, 1, 32'h30, 1, 1);
      step("R9", 10'h081, 0, 1, 32'h30, 1, 1);
      step("R9", 10'h282, 1, 0, 0, 1, 1);
      step("R9", 10'h281, 1, 0, 0, 1, 1);
      // random traffic against the model
      for (int i = 0; i < 400; i++) begin
         logic [9:0] a;
         case ($urandom_range(0, 3))
            0: a = 10'h280;
            1: a = 10'h282;
            2: a = 10'h081;
            default: a = 10'h281;
         endcase
         if ($urandom_range(0, 1) == 0) a = 10'h281;
         step("R8", a, 1'($urandom), ($urandom_range(0, 3) == 0), $urandom,
              1'($urandom), 1'($urandom));
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule